// File: doc/BRIEF.md
# Two-Segment Real-Time Clock Counter

This block keeps time in two parts. A coarse counter runs at all times on a slow, always-on reference clock. A fine counter runs on a fast clock produced by a phase-locked loop that locks to that reference. The fine counter divides the fast clock by N. Its terminal count is the feedback pulse that goes to the phase comparator. It also supplies the low-order digits of the time. The fast clock is only present in a short window before a scheduled event, so the fine counter is armed only for that window. Once armed, it starts from zero on a reference edge. From then on it carries into the coarse field each time it wraps.

Three divide ratios are offered, 16, 32 and 64. They suit a reference at 1/16, 1/32 or 1/64 of the fast-clock rate. The ratio can change only while the fine counter is disarmed. The caller supplies a compare time laid out like the timestamp. When the running counter reaches the compare time, a one-cycle strobe fires and carries the compare value's sub-period tap index. That index picks a phase of the oscillator ring for the analog delay path, which lies outside this block. Outputs are registered in the fast-clock domain. The reference count crosses into that domain through a synchroniser chain.

Top module: `rtc_two_segment`

## Requirements
- R1: The coarse field of `timestamp` (its top COARSE_W bits) equals the number of `clk_ref` rising edges since reset, modulo 2^COARSE_W. It takes each new value SYNC_STAGES+1 `clk_fast` cycles after the reference edge, whether or not the fine counter is armed.
- R2: `sel_code` selects the divide ratio: 0 gives N=16, 1 gives N=32, 2 gives N=64. Reset selects code 1 (N=32).
- R3: When `fine_en` rises, the fine field stays 0 until the next reference edge arrives through the synchroniser. The fine field then reads 0 in the same cycle that the coarse field takes that edge's count. After that it rises by one per `clk_fast` cycle, and on wrapping from N-1 to 0 it adds one to the coarse field.
- R4: `timestamp` is {coarse, fine, tap}. The fine field is 6 bits wide and holds the count in its low log2(N) bits, so it never exceeds N-1. The tap field (low TAP_W bits) reads 0.
- R5: While `fine_en` is low, the fine field reads 0, `div_fb` stays low and no event fires. This takes effect from the cycle after `fine_en` is sampled low.
- R6: `div_fb` is high exactly in those cycles where the counter is running and the fine field reads N-1.
- R7: `evt` is high for one `clk_fast` cycle, the cycle after `timestamp` shows the coarse and fine fields of `cmp_time` while running. `evt_tap` then holds the tap field of `cmp_time` (its low TAP_W bits). At all other times `evt` and `evt_tap` are 0.
- R8: A `sel_wr` pulse with a code of 0 to 2 is accepted only while the fine counter is disarmed (not armed, not running). The new ratio applies from the next cycle.
- R9: A `sel_wr` pulse is ignored when the fine counter is armed or running, or when the code is 3. The ratio stays unchanged and `sel_err` is high for the one cycle after the write.
- R10: After reset, `timestamp`, `div_fb`, `evt`, `evt_tap` and `sel_err` are all 0.
- R11: The coarse field wraps from 2^COARSE_W-1 to 0 with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock from the locked oscillator |
| clk_ref | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset, held over several reference cycles |
| fine_en | input | 1 | Arms the fine counter (fast-clock domain) |
| sel_wr | input | 1 | One-cycle request to change the divide ratio |
| sel_code | input | 2 | Requested ratio code (0:16, 1:32, 2:64) |
| cmp_time | input | COARSE_W+9 | Event time: {coarse, 6-bit fine, 3-bit tap} |
| timestamp | output | COARSE_W+9 | Current time: {coarse, 6-bit fine, 3-bit zero tap} |
| div_fb | output | 1 | Divider feedback pulse for the phase comparator |
| evt | output | 1 | One-cycle event-match strobe |
| evt_tap | output | 3 | Tap index that goes with the strobe |
| sel_err | output | 1 | One-cycle flag for a refused ratio write |

## Verification
The assertions assume the loop is locked, so that every reference period spans exactly N fast cycles. They also assume `cmp_time` stays constant while the counter is running and that ratio writes last a single cycle. The bench builds the reference clock by dividing its own fast clock by the current ratio. It changes that ratio only while the counter is disarmed, when the block's carry chain does not depend on it. It changes `cmp_time` only between runs, and it issues every write as a one-cycle pulse. Under these conditions the carry into the coarse field and the arrival of the synchronised reference edge always fall in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FINE_W = 6;

  typedef enum logic [1:0] {
    DIV_16   = 2'd0,
    DIV_32   = 2'd1,
    DIV_64   = 2'd2,
    DIV_NONE = 2'd3
  } div_code_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ALIGN = 2'd1,
    FS_RUN   = 2'd2
  } fine_state_e;

  // Highest fine count (N-1) for a ratio code
  function automatic logic [FINE_W-1:0] div_last(input div_code_e c);
    case (c)
      DIV_16:  return 6'd15;
      DIV_64:  return 6'd63;
      default: return 6'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_coarse_cnt.sv
module rtc_coarse_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_ref,
  input  logic          rst,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk_ref) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], d};
  end

  // Any change of the synchronised level marks one reference edge
  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/rtc_fine_seg.sv
module rtc_fine_seg
  import rtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ref_edge,
  input  logic [CW-1:0]     coarse_in,
  input  logic              sel_wr,
  input  logic [1:0]        sel_code,
  output logic [CW-1:0]     coarse_q,
  output logic [FINE_W-1:0] fine_q,
  output logic              fb_q,
  output logic              sel_err_q,
  output logic              run,
  output logic              idle,
  output logic [1:0]        sel_q
);
  fine_state_e       st, st_n;
  div_code_e         sel_r;
  logic [CW-1:0]     coarse_n;
  logic [FINE_W-1:0] fine_n, last;
  logic              accept;

  always_comb begin
    last     = div_last(sel_r);
    st_n     = st;
    coarse_n = coarse_q;
    fine_n   = fine_q;
    case (st)
      FS_IDLE: begin
        fine_n = '0;
        if (ref_edge) coarse_n = coarse_in;
        if (en) st_n = FS_ALIGN;
      end
      FS_ALIGN: begin
        fine_n = '0;
        if (ref_edge) coarse_n = coarse_in;
        if (!en)           st_n = FS_IDLE;
        else if (ref_edge) st_n = FS_RUN;
      end
      FS_RUN: begin
        if (!en) begin
          st_n   = FS_IDLE;
          fine_n = '0;
          if (ref_edge) coarse_n = coarse_in;
        end else if (fine_q == last) begin
          fine_n   = '0;
          coarse_n = coarse_q + 1'b1;
        end else begin
          fine_n = fine_q + 1'b1;
        end
      end
      default: st_n = FS_IDLE;
    endcase
    accept = sel_wr && (st == FS_IDLE) && (div_code_e'(sel_code) != DIV_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_IDLE;
      sel_r     <= DIV_32;
      coarse_q  <= '0;
      fine_q    <= '0;
      fb_q      <= 1'b0;
      sel_err_q <= 1'b0;
    end else begin
      st        <= st_n;
      coarse_q  <= coarse_n;
      fine_q    <= fine_n;
      fb_q      <= (st_n == FS_RUN) && (fine_n == last);
      sel_err_q <= sel_wr && !accept;
      if (accept) sel_r <= div_code_e'(sel_code);
    end
  end

  assign run   = (st == FS_RUN);
  assign idle  = (st == FS_IDLE);
  assign sel_q = sel_r;
endmodule

// File: rtl/rtc_event_match.sv
module rtc_event_match #(
  parameter int CW    = 16,
  parameter int FW    = 6,
  parameter int TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CW-1:0]    coarse,
  input  logic [FW-1:0]    fine,
  input  logic [CW-1:0]    cmp_coarse,
  input  logic [FW-1:0]    cmp_fine,
  input  logic [TAP_W-1:0] cmp_tap,
  output logic             evt_q,
  output logic [TAP_W-1:0] tap_q
);
  logic hit;
  assign hit = run && (coarse == cmp_coarse) && (fine == cmp_fine);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      tap_q <= '0;
    end else begin
      evt_q <= hit;
      tap_q <= hit ? cmp_tap : '0;
    end
  end
endmodule

// File: rtl/rtc_two_segment.sv
module rtc_two_segment
  import rtc_pkg::*;
#(
  parameter int COARSE_W    = 16,
  parameter int TAP_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int TS_W       = COARSE_W + FINE_W + TAP_W
) (
  input  logic             clk_fast,
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             fine_en,
  input  logic             sel_wr,
  input  logic [1:0]       sel_code,
  input  logic [TS_W-1:0]  cmp_time,
  output logic [TS_W-1:0]  timestamp,
  output logic             div_fb,
  output logic             evt,
  output logic [TAP_W-1:0] evt_tap,
  output logic             sel_err
);
  logic [COARSE_W-1:0] coarse_ref, coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic                ref_edge, fine_run, fine_idle;
  logic [1:0]          sel_q;

  rtc_coarse_cnt #(.CW(COARSE_W)) u_coarse (
    .clk_ref (clk_ref),
    .rst     (rst),
    .count   (coarse_ref)
  );

  // Bit 0 toggles on every reference increment; the count is stable for N fast cycles
  rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_fast),
    .rst   (rst),
    .d     (coarse_ref[0]),
    .pulse (ref_edge)
  );

  rtc_fine_seg #(.CW(COARSE_W)) u_fine (
    .clk       (clk_fast),
    .rst       (rst),
    .en        (fine_en),
    .ref_edge  (ref_edge),
    .coarse_in (coarse_ref),
    .sel_wr    (sel_wr),
    .sel_code  (sel_code),
    .coarse_q  (coarse_q),
    .fine_q    (fine_q),
    .fb_q      (div_fb),
    .sel_err_q (sel_err),
    .run       (fine_run),
    .idle      (fine_idle),
    .sel_q     (sel_q)
  );

  rtc_event_match #(.CW(COARSE_W), .FW(FINE_W), .TAP_W(TAP_W)) u_evt (
    .clk        (clk_fast),
    .rst        (rst),
    .run        (fine_run),
    .coarse     (coarse_q),
    .fine       (fine_q),
    .cmp_coarse (cmp_time[TS_W-1 -: COARSE_W]),
    .cmp_fine   (cmp_time[TAP_W +: FINE_W]),
    .cmp_tap    (cmp_time[TAP_W-1:0]),
    .evt_q      (evt),
    .tap_q      (evt_tap)
  );

  assign timestamp = {coarse_q, fine_q, {TAP_W{1'b0}}};
endmodule

// File: rtl/rtc_two_segment_chk.sv
module rtc_two_segment_chk
  import rtc_pkg::*;
#(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     coarse,
  input logic [FINE_W-1:0] fine,
  input logic              div_fb,
  input logic              evt,
  input logic              sel_err,
  input logic              sel_wr,
  input logic              run,
  input logic              idle,
  input logic [1:0]        sel_q
);
  p_fine_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && fine != '0) |-> (fine == $past(fine) + 1'b1))
    else $error("fine count did not step by one");

  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && fine == '0) |-> (coarse == $past(coarse) + 1'b1))
    else $error("fine wrap did not carry into coarse");

  p_fine_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fine <= div_last(div_code_e'(sel_q)))
    else $error("fine count beyond N-1");

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    idle |-> (fine == '0 && !div_fb))
    else $error("disarmed counter not quiet");

  p_fb_top_r6: assert property (@(posedge clk) disable iff (rst)
    div_fb |-> (run && fine == div_last(div_code_e'(sel_q))))
    else $error("feedback pulse away from terminal count");

  p_evt_single_r7: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt)
    else $error("event strobe longer than one cycle");

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(sel_q))
    else $error("ratio changed while armed");

  p_sel_err_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && !idle) |=> sel_err)
    else $error("refused write not flagged");
endmodule

bind rtc_two_segment rtc_two_segment_chk #(.CW(COARSE_W)) u_chk (
  .clk     (clk_fast),
  .rst     (rst),
  .coarse  (coarse_q),
  .fine    (fine_q),
  .div_fb  (div_fb),
  .evt     (evt),
  .sel_err (sel_err),
  .sel_wr  (sel_wr),
  .run     (fine_run),
  .idle    (fine_idle),
  .sel_q   (sel_q)
);

// File: tb/tb_rtc_two_segment.sv
module tb_rtc_two_segment;
  localparam int CW  = 8;
  localparam int TW  = CW + 9;
  localparam int LAT = 3;

  logic          fclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic          fine_en = 1'b0, sel_wr = 1'b0;
  logic [1:0]    sel_code = 2'd0;
  logic [TW-1:0] cmp_time = '0;
  logic [TW-1:0] timestamp;
  logic          div_fb, evt, sel_err;
  logic [2:0]    evt_tap;

  int ph = 0, bn = 32;
  logic [CW-1:0] cnt = '0, lag = '0;

  int  checks = 0, errors = 0, en_cnt = 0, evt_seen = 0, max_fine = 0;
  bit  checking = 0, run_exp = 0, prev_match = 0, exp_err = 0, done = 0;
  logic [2:0] prev_tap = '0;

  rtc_two_segment #(.COARSE_W(CW), .TAP_W(3), .SYNC_STAGES(2)) dut (
    .clk_fast (fclk), .clk_ref (rclk), .rst (rst), .fine_en (fine_en),
    .sel_wr (sel_wr), .sel_code (sel_code), .cmp_time (cmp_time),
    .timestamp (timestamp), .div_fb (div_fb), .evt (evt),
    .evt_tap (evt_tap), .sel_err (sel_err)
  );

  always #2ns fclk = ~fclk;

  // Reference clock: one period every bn fast cycles; cnt models its edge count
  always @(posedge fclk) begin : ref_gen
    int nx;
    nx = (ph >= bn - 1) ? 0 : ph + 1;
    ph <= nx;
    rclk <= (nx < bn / 2);
    if (nx == 0) begin
      if (rst) begin cnt <= '0; lag <= '0; end
      else begin lag <= cnt; cnt <= cnt + 8'd1; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [CW-1:0] ec;
    logic [5:0]    ef;
    logic [TW-1:0] ets;
    bit            efb;
    @(negedge fclk);
    if (!fine_en) begin run_exp = 0; en_cnt = 0; end
    else begin
      en_cnt++;
      if (!run_exp && en_cnt >= 2 && ph == LAT) run_exp = 1;
    end
    ec = (ph >= LAT) ? cnt : lag;
    ef = run_exp ? 6'((ph >= LAT) ? ph - LAT : ph + bn - LAT) : 6'd0;
    ets = {ec, ef, 3'b000};
    efb = run_exp && (int'(ef) == bn - 1);
    if (checking) begin
      chk(timestamp === ets, run_exp ? "R1 R3 R4 R11 timestamp" : "R1 R5 R11 timestamp",
          32'(timestamp), 32'(ets));
      chk(div_fb === efb, run_exp ? "R6 div_fb" : "R5 div_fb", 32'(div_fb), 32'(efb));
      chk(evt === prev_match, "R7 evt", 32'(evt), 32'(prev_match));
      chk(evt_tap === (prev_match ? prev_tap : 3'd0), "R7 evt_tap", 32'(evt_tap),
          32'(prev_match ? prev_tap : 3'd0));
      chk(sel_err === exp_err, "R9 sel_err", 32'(sel_err), 32'(exp_err));
    end
    if (evt === 1'b1) evt_seen++;
    if (run_exp && int'(timestamp[8:3]) > max_fine) max_fine = int'(timestamp[8:3]);
    prev_match = run_exp && ec == cmp_time[TW-1:9] && ef == cmp_time[8:3];
    prev_tap   = cmp_time[2:0];
    exp_err    = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_ph(input int p);
    step();
    while (ph != p) step();
  endtask

  function automatic int ratio(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd2) ? 64 : 32;
  endfunction

  // One-cycle ratio write; ok says whether the block should take it
  task automatic wr(input logic [1:0] c, input bit ok);
    sel_code = c;
    sel_wr   = 1'b1;
    if (ok) bn = ratio(c);
    exp_err  = !ok;
    step();
    sel_wr   = 1'b0;
  endtask

  task automatic arm();
    wait_ph(10);
    fine_en = 1'b1;
  endtask

  task automatic disarm();
    fine_en = 1'b0;
    steps(2);
  endtask

  task automatic run_one(input int f, input int tap);
    wait_ph(10);
    cmp_time = {cnt + 8'd2, 6'(f), 3'(tap)};
    fine_en  = 1'b1;
    evt_seen = 0;
    max_fine = 0;
    steps(4 * bn);
    disarm();
    chk(evt_seen == 1, "R7 one strobe per match", 32'(evt_seen), 32'd1);
  endtask

  initial begin
    steps(400);
    chk(timestamp === '0, "R10 timestamp", 32'(timestamp), 32'd0);
    chk(div_fb === 1'b0 && evt === 1'b0, "R10 div_fb/evt", {30'd0, div_fb, evt}, 32'd0);
    chk(evt_tap === 3'd0 && sel_err === 1'b0, "R10 evt_tap/sel_err",
        {28'd0, evt_tap, sel_err}, 32'd0);
    rst = 1'b0;
    checking = 1;
    steps(200);

    // Reset ratio is 32 (R2)
    run_one(5, 3);
    chk(max_fine == 31, "R2 reset ratio", 32'(max_fine), 32'd31);

    // Sweep every ratio and every fine compare value
    for (int c = 2; c >= 0; c--) begin
      wr(2'(c), 1'b1);
      steps(3 * bn);
      for (int f = 0; f < bn; f++) begin
        run_one(f, f % 8);
        chk(max_fine == bn - 1, "R2 R8 ratio in use", 32'(max_fine), 32'(bn - 1));
      end
    end

    // Write while running is refused (R9)
    arm();
    max_fine = 0;
    steps(2 * bn);
    wr(2'd2, 1'b0);
    steps(2 * bn);
    disarm();
    chk(max_fine == 15, "R9 ratio kept after write while running", 32'(max_fine), 32'd15);

    // Code 3 while disarmed is refused (R9)
    wr(2'd3, 1'b0);
    run_one(7, 6);
    chk(max_fine == 15, "R9 ratio kept after bad code", 32'(max_fine), 32'd15);

    // Write while armed but not yet running is refused (R9)
    arm();
    max_fine = 0;
    step();
    wr(2'd1, 1'b0);
    steps(3 * bn);
    disarm();
    chk(max_fine == 15, "R9 ratio kept after write while armed", 32'(max_fine), 32'd15);

    steps(50);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule